// File: doc/BRIEF.md
# Register-Space Address Router

This block sits in front of several register blocks and routes software accesses to them. Every block owns a contiguous window of addresses. The window starts at the block's base address and is as long as the block's effective size. The effective size is either a per-block override or, when the override is zero, a default shared by all blocks. A block's local offset width is the bit length of its effective size minus one. The low address bits, as many as that width, are forwarded to the block as its offset.

Reads and writes travel on two independent ports. Each port has its own enable and address, and each can be left out of a configuration by a parameter. A write reaches at most one block. Only that block's write enable rises, and the write data goes to all blocks unchanged. A read enables only the selected block. The block's response comes back `RD_LAT` cycles later. It is steered through a one-hot select that was captured when the read was issued. Accesses that hit no window are absorbed: a write changes nothing and a read returns zero.

Top module: `csr_addr_router`

## Requirements
- R1: Block i is selected by an access when BLOCK_BASE[i] <= address < BLOCK_BASE[i] + size_i. size_i is BLOCK_SIZE[i], or DEFAULT_SIZE when BLOCK_SIZE[i] is 0. Bit i of `blkWrEn`/`blkRdEn` belongs to block i.
- R2: At most one bit of `blkWrEn` is set, and none is set while `wrEn` is low.
- R3: Field i of `blkWrAddr`/`blkRdAddr` occupies bits [i*OFFW_MAX +: OFFW_MAX]. For the selected block it holds address minus base, zero-extended. The field width in use is the bit length of size_i - 1.
- R4: `blkWrData` equals `wrData` in every cycle.
- R5: A write outside every window raises no block write enable, including addresses one past the end of a window.
- R6: A read of a mapped address raises only the selected block's `blkRdEn`. After RD_LAT clock edges, `rdData` equals that block's `blkRdData` field, which occupies bits [i*DATA_W +: DATA_W].
- R7: `rdData` is zero in the response cycle of an unmapped read, and in any cycle with no read issued RD_LAT edges earlier.
- R8: Back-to-back reads, a mapped one followed by an unmapped one, return the block data and then zero, each in its own response cycle.
- R9: A write and a read in the same cycle to different blocks are both carried out.
- R10: With HAS_WR = 0, no block write enable ever rises. With HAS_RD = 0, no block read enable rises and `rdData` stays zero.
- R11: During and right after reset, `rdData` is zero and no block enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data, RD_LAT cycles after the request |
| blkWrEn | output | NUM_BLOCKS | Per-block write enable |
| blkWrAddr | output | NUM_BLOCKS*OFFW_MAX | Per-block write offsets |
| blkWrData | output | DATA_W | Write data to all blocks |
| blkRdEn | output | NUM_BLOCKS | Per-block read enable |
| blkRdAddr | output | NUM_BLOCKS*OFFW_MAX | Per-block read offsets |
| blkRdData | input | NUM_BLOCKS*DATA_W | Per-block read responses |

## Verification
The block enables, the forwarded offsets and the write data are combinational. The bench therefore checks them 1 ns after driving inputs on a falling clock edge, before the next rising edge. Read data is due after one rising edge with the default RD_LAT of 1. The bench samples it on the following falling edge, at the moment it drives the next request, because `rdData` depends only on registered state. For back-to-back reads, each response is checked one falling edge apart, so a later unmapped read cannot hide a stale result.

// File: rtl/csr_router_pkg.sv
package csr_router_pkg;

  localparam int MAX_BLOCKS = 8;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic [MAX_BLOCKS-1:0] wrSel;
    logic [MAX_BLOCKS-1:0] rdSel;
  } routeStrb_t;

  function automatic int bitLen(input int v);
    int n;
    n = 0;
    for (int k = 0; k < 31; k++) begin
      if ((v >> k) != 0) n = k + 1;
    end
    return n;
  endfunction

  function automatic int effSize(input int ovr, input int dflt);
    return (ovr == 0) ? dflt : ovr;
  endfunction

endpackage

// File: rtl/csr_router_decode.sv
module csr_router_decode
  import csr_router_pkg::*;
#(
  parameter int NUM_BLOCKS = 3,
  parameter int ADDR_W = 10,
  parameter int DEFAULT_SIZE = 16,
  parameter int BLOCK_BASE [NUM_BLOCKS] = '{0, 64, 256},
  parameter int BLOCK_SIZE [NUM_BLOCKS] = '{0, 40, 0},
  parameter bit HAS_WR = 1'b1,
  parameter bit HAS_RD = 1'b1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output routeStrb_t        strb
);

  logic [NUM_BLOCKS-1:0] wrHit;
  logic [NUM_BLOCKS-1:0] rdHit;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_win
    localparam int LO = BLOCK_BASE[i];
    localparam int HI = LO + effSize(BLOCK_SIZE[i], DEFAULT_SIZE);
    assign wrHit[i] = (int'(wrAddr) >= LO) && (int'(wrAddr) < HI);
    assign rdHit[i] = (int'(rdAddr) >= LO) && (int'(rdAddr) < HI);
  end

  always_comb begin
    strb = '0;
    if (HAS_WR) strb.wrSel[NUM_BLOCKS-1:0] = wrEn ? wrHit : '0;
    if (HAS_RD) strb.rdSel[NUM_BLOCKS-1:0] = rdEn ? rdHit : '0;
  end

endmodule

// File: rtl/csr_router_datapath.sv
module csr_router_datapath
  import csr_router_pkg::*;
#(
  parameter int NUM_BLOCKS = 3,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int DEFAULT_SIZE = 16,
  parameter int BLOCK_SIZE [NUM_BLOCKS] = '{0, 40, 0},
  parameter int OFFW_MAX = 6,
  parameter int RD_LAT = 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  routeStrb_t                     strb,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [ADDR_W-1:0]              rdAddr,
  input  logic [NUM_BLOCKS*DATA_W-1:0]   blkRdData,
  output logic [NUM_BLOCKS-1:0]          blkWrEn,
  output logic [NUM_BLOCKS*OFFW_MAX-1:0] blkWrAddr,
  output logic [DATA_W-1:0]              blkWrData,
  output logic [NUM_BLOCKS-1:0]          blkRdEn,
  output logic [NUM_BLOCKS*OFFW_MAX-1:0] blkRdAddr,
  output logic [DATA_W-1:0]              rdData
);

  localparam int SPARE = MAX_BLOCKS - NUM_BLOCKS;

  assign blkWrEn   = strb.wrSel[NUM_BLOCKS-1:0];
  assign blkRdEn   = strb.rdSel[NUM_BLOCKS-1:0];
  assign blkWrData = wrData;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_off
    localparam int OW = bitLen(effSize(BLOCK_SIZE[i], DEFAULT_SIZE) - 1);
    localparam logic [ADDR_W-1:0] MASK = ADDR_W'((64'(1) << OW) - 64'(1));
    assign blkWrAddr[i*OFFW_MAX +: OFFW_MAX] = OFFW_MAX'(wrAddr & MASK);
    assign blkRdAddr[i*OFFW_MAX +: OFFW_MAX] = OFFW_MAX'(rdAddr & MASK);
  end

  if (SPARE > 0) begin : g_spare
    logic unusedSpare;
    assign unusedSpare = ^{strb.wrSel[MAX_BLOCKS-1:NUM_BLOCKS],
                           strb.rdSel[MAX_BLOCKS-1:NUM_BLOCKS]};
  end

  // select captured at issue travels alongside the block's response latency
  logic [RD_LAT-1:0][NUM_BLOCKS-1:0] selPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPipe <= '0;
    end else begin
      selPipe[0] <= strb.rdSel[NUM_BLOCKS-1:0];
      for (int k = 1; k < RD_LAT; k++) selPipe[k] <= selPipe[k-1];
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (selPipe[RD_LAT-1][i]) rdData = rdData | blkRdData[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/csr_addr_router.sv
module csr_addr_router
  import csr_router_pkg::*;
#(
  parameter int NUM_BLOCKS = 3,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int DEFAULT_SIZE = 16,
  parameter int BLOCK_BASE [NUM_BLOCKS] = '{0, 64, 256},
  parameter int BLOCK_SIZE [NUM_BLOCKS] = '{0, 40, 0},
  parameter int OFFW_MAX = 6,
  parameter int RD_LAT = 1,
  parameter bit HAS_WR = 1'b1,
  parameter bit HAS_RD = 1'b1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [DATA_W-1:0]              wrData,
  input  logic                           rdEn,
  input  logic [ADDR_W-1:0]              rdAddr,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_BLOCKS-1:0]          blkWrEn,
  output logic [NUM_BLOCKS*OFFW_MAX-1:0] blkWrAddr,
  output logic [DATA_W-1:0]              blkWrData,
  output logic [NUM_BLOCKS-1:0]          blkRdEn,
  output logic [NUM_BLOCKS*OFFW_MAX-1:0] blkRdAddr,
  input  logic [NUM_BLOCKS*DATA_W-1:0]   blkRdData
);

  // elaboration-time parameter checks
  if (NUM_BLOCKS > MAX_BLOCKS || NUM_BLOCKS < 1) begin : g_badCount
    $error("block count out of range");
  end
  if (RD_LAT < 1) begin : g_badLat
    $error("read latency must be at least one");
  end

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_chkBlk
    localparam int SZ = effSize(BLOCK_SIZE[i], DEFAULT_SIZE);
    localparam int OW = bitLen(SZ - 1);
    if (SZ < 1) begin : g_badSize
      $error("block size must be positive");
    end
    if (OW > OFFW_MAX) begin : g_badOffw
      $error("offset field too narrow for block");
    end
    if ((BLOCK_BASE[i] % (1 << OW)) != 0) begin : g_badAlign
      $error("block base not aligned to its offset width");
    end
    if (BLOCK_BASE[i] + SZ > (1 << ADDR_W)) begin : g_badTop
      $error("block window exceeds the address width");
    end
    for (genvar j = i + 1; j < NUM_BLOCKS; j++) begin : g_pair
      localparam int SZJ = effSize(BLOCK_SIZE[j], DEFAULT_SIZE);
      localparam bit CLASH = (BLOCK_BASE[i] == BLOCK_BASE[j]) ||
        ((BLOCK_BASE[i] < BLOCK_BASE[j]) && (BLOCK_BASE[j] - BLOCK_BASE[i] < SZ)) ||
        ((BLOCK_BASE[j] < BLOCK_BASE[i]) && (BLOCK_BASE[i] - BLOCK_BASE[j] < SZJ));
      if (CLASH) begin : g_overlap
        $error("block windows overlap");
      end
    end
  end

  routeStrb_t strb;

  csr_router_decode #(
    .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .DEFAULT_SIZE(DEFAULT_SIZE),
    .BLOCK_BASE(BLOCK_BASE), .BLOCK_SIZE(BLOCK_SIZE),
    .HAS_WR(HAS_WR), .HAS_RD(HAS_RD)
  ) u_decode (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  csr_router_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DEFAULT_SIZE(DEFAULT_SIZE), .BLOCK_SIZE(BLOCK_SIZE),
    .OFFW_MAX(OFFW_MAX), .RD_LAT(RD_LAT)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .blkRdData(blkRdData),
    .blkWrEn(blkWrEn), .blkWrAddr(blkWrAddr), .blkWrData(blkWrData),
    .blkRdEn(blkRdEn), .blkRdAddr(blkRdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/csr_addr_router_chk.sv
module csr_addr_router_chk
  import csr_router_pkg::*;
#(
  parameter int NUM_BLOCKS = 3,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int DEFAULT_SIZE = 16,
  parameter int BLOCK_BASE [NUM_BLOCKS] = '{0, 64, 256},
  parameter int BLOCK_SIZE [NUM_BLOCKS] = '{0, 40, 0},
  parameter int OFFW_MAX = 6,
  parameter int RD_LAT = 1
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           wrEn,
  input logic [ADDR_W-1:0]              wrAddr,
  input logic                           rdEn,
  input logic [ADDR_W-1:0]              rdAddr,
  input logic [DATA_W-1:0]              rdData,
  input logic [NUM_BLOCKS-1:0]          blkWrEn,
  input logic [NUM_BLOCKS*OFFW_MAX-1:0] blkWrAddr,
  input logic [NUM_BLOCKS-1:0]          blkRdEn,
  input logic [NUM_BLOCKS*OFFW_MAX-1:0] blkRdAddr,
  input logic [NUM_BLOCKS*DATA_W-1:0]   blkRdData
);

  // history of issued block reads, built from the port enables
  logic [RD_LAT-1:0][NUM_BLOCKS-1:0] hist;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
    end else begin
      hist[0] <= blkRdEn;
      for (int k = 1; k < RD_LAT; k++) hist[k] <= hist[k-1];
    end
  end

  a_r2_wr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blkWrEn));
  a_r2_wr_idle: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> blkWrEn == '0);
  a_r6_rd_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blkRdEn));
  a_r6_rd_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> blkRdEn == '0);
  a_r7_rd_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hist[RD_LAT-1] == '0) |-> rdData == '0);

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    localparam int LO = BLOCK_BASE[i];
    localparam int HI = LO + effSize(BLOCK_SIZE[i], DEFAULT_SIZE);
    a_r1_wr_window: assert property (@(posedge clk) disable iff (!rstN)
      blkWrEn[i] |-> (int'(wrAddr) >= LO) && (int'(wrAddr) < HI));
    a_r1_rd_window: assert property (@(posedge clk) disable iff (!rstN)
      blkRdEn[i] |-> (int'(rdAddr) >= LO) && (int'(rdAddr) < HI));
    a_r3_wr_offset: assert property (@(posedge clk) disable iff (!rstN)
      blkWrEn[i] |-> int'(wrAddr) == LO + int'(blkWrAddr[i*OFFW_MAX +: OFFW_MAX]));
    a_r3_rd_offset: assert property (@(posedge clk) disable iff (!rstN)
      blkRdEn[i] |-> int'(rdAddr) == LO + int'(blkRdAddr[i*OFFW_MAX +: OFFW_MAX]));
    a_r6_rd_return: assert property (@(posedge clk) disable iff (!rstN)
      hist[RD_LAT-1][i] |-> rdData == blkRdData[i*DATA_W +: DATA_W]);
  end

endmodule

bind csr_addr_router csr_addr_router_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .DEFAULT_SIZE(DEFAULT_SIZE), .BLOCK_BASE(BLOCK_BASE), .BLOCK_SIZE(BLOCK_SIZE),
  .OFFW_MAX(OFFW_MAX), .RD_LAT(RD_LAT)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn),
  .rdAddr(rdAddr), .rdData(rdData), .blkWrEn(blkWrEn), .blkWrAddr(blkWrAddr),
  .blkRdEn(blkRdEn), .blkRdAddr(blkRdAddr), .blkRdData(blkRdData)
);

// File: tb/csr_addr_router_bench.sv
module csr_addr_router_bench;

  localparam int NB = 3;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int OW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;

  logic [DW-1:0]    rdData, altRdData;
  logic [NB-1:0]    blkWrEn, blkRdEn, altWrEn, altRdEn;
  logic [NB*OW-1:0] blkWrAddr, blkRdAddr, altWrAddr, altRdAddr;
  logic [DW-1:0]    blkWrData, altWrData;
  logic [NB*DW-1:0] blkRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  csr_addr_router u_csr_addr_router (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .blkWrEn(blkWrEn), .blkWrAddr(blkWrAddr), .blkWrData(blkWrData),
    .blkRdEn(blkRdEn), .blkRdAddr(blkRdAddr), .blkRdData(blkRdData)
  );

  // second instance with both ports configured out
  csr_addr_router #(.HAS_WR(1'b0), .HAS_RD(1'b0)) u_csr_addr_router_off (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(altRdData),
    .blkWrEn(altWrEn), .blkWrAddr(altWrAddr), .blkWrData(altWrData),
    .blkRdEn(altRdEn), .blkRdAddr(altRdAddr), .blkRdData(blkRdData)
  );

  // register block models, one response cycle
  logic [DW-1:0] mem [NB][64];
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (blkWrEn[b]) mem[b][blkWrAddr[b*OW +: OW]] <= blkWrData;
      if (blkRdEn[b]) blkRdData[b*DW +: DW] <= mem[b][blkRdAddr[b*OW +: OW]];
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic int blkIdx(input logic [NB-1:0] en);
    int r = 0;
    for (int b = 0; b < NB; b++) if (en[b]) r = b;
    return r;
  endfunction

  task automatic doWrite(input int addr, input int data, input logic [NB-1:0] expEn,
                         input int expOff, input string req);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(addr); wrData = DW'(data);
    #1;
    check(req, "write enables", int'(blkWrEn), int'(expEn));
    if (expEn != '0)
      check("R3", "write offset", int'(blkWrAddr[blkIdx(expEn)*OW +: OW]), expOff);
    check("R4", "write data", int'(blkWrData), data);
    check("R10", "disabled write enables", int'(altWrEn), 0);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input int addr, input logic [NB-1:0] expEn, input int expData,
                        input string req);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = AW'(addr);
    #1;
    check(req, "read enables", int'(blkRdEn), int'(expEn));
    check("R10", "disabled read enables", int'(altRdEn), 0);
    @(negedge clk);
    rdEn = 1'b0;
    #1;
    check(req, "read data", int'(rdData), expData);
    check("R10", "disabled read data", int'(altRdData), 0);
  endtask

  task automatic tReset();
    #1;
    check("R11", "rdData in reset", int'(rdData), 0);
    check("R11", "write enables in reset", int'(blkWrEn), 0);
    check("R11", "read enables in reset", int'(blkRdEn), 0);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R11", "rdData after reset", int'(rdData), 0);
  endtask

  task automatic tWrites();
    doWrite(12'h005, 16'hA005, 3'b001, 5,  "R1");
    doWrite(12'h00F, 16'hA00F, 3'b001, 15, "R1");
    doWrite(12'h040, 16'hB040, 3'b010, 0,  "R1");
    doWrite(12'h067, 16'hB067, 3'b010, 39, "R1");
    doWrite(12'h100, 16'hC100, 3'b100, 0,  "R1");
    doWrite(12'h10F, 16'hC10F, 3'b100, 15, "R1");
  endtask

  task automatic tUnmappedWrites();
    doWrite(12'h010, 16'h1111, 3'b000, 0, "R5");
    doWrite(12'h068, 16'h2222, 3'b000, 0, "R5");
    doWrite(12'h110, 16'h3333, 3'b000, 0, "R5");
    doWrite(12'h3FF, 16'h4444, 3'b000, 0, "R5");
  endtask

  task automatic tReads();
    doRead(12'h005, 3'b001, 16'hA005, "R6");
    doRead(12'h067, 3'b010, 16'hB067, "R6");
    doRead(12'h040, 3'b010, 16'hB040, "R6");
    doRead(12'h10F, 3'b100, 16'hC10F, "R6");
    doRead(12'h00F, 3'b001, 16'hA00F, "R6");
  endtask

  task automatic tUnmappedReads();
    doRead(12'h068, 3'b000, 0, "R7");
    doRead(12'h010, 3'b000, 0, "R7");
    @(negedge clk); #1;
    check("R7", "idle rdData", int'(rdData), 0);
  endtask

  task automatic tBackToBack();
    @(negedge clk);
    rdEn = 1'b1; rdAddr = AW'(12'h10F);
    @(negedge clk);
    rdAddr = AW'(12'h110);
    #1;
    check("R8", "first response", int'(rdData), 16'hC10F);
    @(negedge clk);
    rdEn = 1'b0;
    #1;
    check("R8", "second response", int'(rdData), 0);
  endtask

  task automatic tConcurrent();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(12'h00A); wrData = 16'hA00A;
    rdEn = 1'b1; rdAddr = AW'(12'h100);
    #1;
    check("R9", "write enable", int'(blkWrEn), 3'b001);
    check("R9", "read enable", int'(blkRdEn), 3'b100);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    #1;
    check("R9", "read data", int'(rdData), 16'hC100);
    doRead(12'h00A, 3'b001, 16'hA00A, "R9");
  endtask

  initial begin
    tReset();
    tWrites();
    tUnmappedWrites();
    tReads();
    tUnmappedReads();
    tBackToBack();
    tConcurrent();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule